// File: doc/BRIEF.md
# Supervisor reset and watchdog controller

This block sits behind the supply comparators of a board or chip supervisor. It takes one flag that says every monitored supply is valid, plus a watchdog kick input that can be low, high or floating. From these it produces an active-low system reset and a latched, active-low watchdog status flag. Both outputs are plain logic levels that enable an output pull-down.

When a supply drops, reset is asserted at once and held for a full reset period after the supplies recover. The watchdog timer starts when reset is released. Software must flip the kick input between low and high before the watchdog period runs out. If it does not, the status flag latches low and reset is asserted for one reset period.

After coming out of reset, the processor reads the flag. A low flag means the reset came from a software timeout. A high flag means it came from an undervoltage. A floating kick input parks the watchdog timer and leaves the flag as it is. Both periods are cycle-count parameters.

Top module: `supv_rst_wdog`

## Requirements
- R1: While the asynchronous power-on reset `por_n` is low, `sys_rst_n` is 0 and `wd_flag_n` is 1.
- R2: In any cycle sampled with `supply_ok` low, the next state has `sys_rst_n` = 0 and `wd_flag_n` = 1, and both timers are cleared. A later recovery therefore waits a full reset period.
- R3: The first clock edge that samples `supply_ok` high after an undervoltage starts the reset period. From that edge `sys_rst_n` stays 0 for exactly `RST_CYCLES` edges, then goes to 1.
- R4: The watchdog count starts at the release of reset. After `WD_CYCLES` counting edges with no kick, `wd_flag_n` goes to 0 and `sys_rst_n` goes to 0 for `RST_CYCLES` edges.
- R5: The kick code is 2'b00 for low, 2'b01 for high, and 2'b10 or 2'b11 for floating. A kick is a change between the low code and the high code, in either direction, from one sampled cycle to the next. A kick restarts the watchdog count. A kick on the very edge where the count would expire also wins over the timeout.
- R6: While `sys_rst_n` is 0, kicks have no effect, and `wd_flag_n` keeps its value.
- R7: With reset released, the first kick sets `wd_flag_n` back to 1.
- R8: With the flag latched low and no kicks, reset periods and watchdog periods alternate: `RST_CYCLES` edges low, then `WD_CYCLES` edges high, and so on.
- R9: A floating kick code stops the watchdog and clears its count without changing `wd_flag_n`. A move from floating to a driven level is not a kick: it starts the count from zero and leaves the flag latched.
- R10: An undervoltage sets a latched-low `wd_flag_n` back to 1. This also holds partway through a reset period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | All monitored supplies valid (synchronous) |
| kick | input | 2 | Watchdog kick code: 00 low, 01 high, 1x floating (synchronous) |
| sys_rst_n | output | 1 | System reset, active low (1 drives the pull-down off) |
| wd_flag_n | output | 1 | Latched watchdog timeout flag, active low |

## Verification
Two pairs of functions can fall in the same cycle.

- **Kick against timeout.** The bench brings the count to its last value and then flips the kick code on the edge where the timeout would fire. It judges that reset stays released and the flag reads 1.
- **Undervoltage against timeout.** The bench drops `supply_ok` on that same last-count edge. It judges that reset is asserted with the flag high, so the event is reported as an undervoltage and not as a timeout.

An undervoltage that lands inside a timeout-caused reset period is also checked; it must clear the flag.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    ST_UV  = 2'd0,
    ST_RST = 2'd1,
    ST_RUN = 2'd2
  } supv_state_e;

  localparam logic [1:0] KICK_LO = 2'b00;
  localparam logic [1:0] KICK_HI = 2'b01;

  // Counter width for a limit of n cycles (at least one bit).
  function automatic int cnt_w(input int n);
    return ($clog2(n) < 1) ? 1 : $clog2(n);
  endfunction

  // True when the kick code is a driven logic level.
  function automatic logic is_driven(input logic [1:0] code);
    return (code == KICK_LO) || (code == KICK_HI);
  endfunction

endpackage

// File: rtl/supv_kick_detect.sv
module supv_kick_detect
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic [1:0] kick,
  output logic       kick_evt,
  output logic       kick_float
);

  logic [1:0] prev_code;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prev_code <= 2'b10;
    else        prev_code <= kick;
  end

  assign kick_float = !is_driven(kick);
  assign kick_evt   = is_driven(kick) && is_driven(prev_code) && (kick != prev_code);

  // A kick never comes out of a floating sample.
  AST_NO_KICK_FROM_FLOAT: assert property (@(posedge clk) disable iff (!por_n)
    $past(kick_float) |-> !kick_evt); // R9

endmodule

// File: rtl/supv_timer.sv
module supv_timer
  import supv_pkg::*;
#(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic clr,
  output logic expire
);

  localparam int W = cnt_w(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] count;

  assign expire = run && !clr && (count == LAST);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)            count <= '0;
    else if (!run || clr)  count <= '0;
    else if (expire)       count <= '0;
    else                   count <= count + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
    count <= LAST); // R3

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    !run |=> count == '0); // R2

endmodule

// File: rtl/supv_rst_wdog.sv
module supv_rst_wdog
  import supv_pkg::*;
#(
  parameter int RST_CYCLES = 16,
  parameter int WD_CYCLES  = 64
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_ok,
  input  logic [1:0] kick,
  output logic       sys_rst_n,
  output logic       wd_flag_n
);

  supv_state_e state;
  logic        flag_q;
  logic        kick_evt;
  logic        kick_float;
  logic        rst_expire;
  logic        wd_expire;
  logic        rst_run;
  logic        wd_run;

  supv_kick_detect u_kick (
    .clk        (clk),
    .por_n      (por_n),
    .kick       (kick),
    .kick_evt   (kick_evt),
    .kick_float (kick_float)
  );

  assign rst_run = (state == ST_RST) && supply_ok;
  assign wd_run  = (state == ST_RUN) && supply_ok && !kick_float;

  supv_timer #(.LIMIT(RST_CYCLES)) u_rst_tmr (
    .clk    (clk),
    .por_n  (por_n),
    .run    (rst_run),
    .clr    (1'b0),
    .expire (rst_expire)
  );

  supv_timer #(.LIMIT(WD_CYCLES)) u_wd_tmr (
    .clk    (clk),
    .por_n  (por_n),
    .run    (wd_run),
    .clr    (kick_evt),
    .expire (wd_expire)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state  <= ST_UV;
      flag_q <= 1'b1;
    end else if (!supply_ok) begin
      state  <= ST_UV;
      flag_q <= 1'b1;
    end else begin
      unique case (state)
        ST_UV:  state <= ST_RST;
        ST_RST: if (rst_expire) state <= ST_RUN;
        ST_RUN: begin
          if (kick_evt) begin
            flag_q <= 1'b1;
          end else if (wd_expire) begin
            flag_q <= 1'b0;
            state  <= ST_RST;
          end
        end
        default: state <= ST_UV;
      endcase
    end
  end

  assign sys_rst_n = (state == ST_RUN);
  assign wd_flag_n = flag_q;

  AST_UV_FORCES: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> (!sys_rst_n && wd_flag_n)); // R2

  AST_FLAG_WITH_RST: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wd_flag_n) |-> $fell(sys_rst_n)); // R4

  AST_KICK_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && supply_ok) |=> wd_flag_n == $past(wd_flag_n)); // R6

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n && supply_ok && kick_evt) |=> (wd_flag_n && sys_rst_n)); // R7

  AST_FLOAT_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst_n && supply_ok && kick_float) |=> (sys_rst_n && wd_flag_n == $past(wd_flag_n))); // R9

endmodule

// File: tb/supv_rst_wdog_tb.sv
`timescale 1ns/1ps
module supv_rst_wdog_tb_top;

  localparam int RST_N = 4;
  localparam int WD_N  = 6;
  localparam logic [1:0] L = 2'b00;
  localparam logic [1:0] H = 2'b01;
  localparam logic [1:0] F = 2'b10;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       supply_ok = 1'b0;
  logic [1:0] kick = F;
  logic       sys_rst_n;
  logic       wd_flag_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #4 clk = ~clk;

  supv_rst_wdog #(.RST_CYCLES(RST_N), .WD_CYCLES(WD_N)) dut_i (
    .clk       (clk),
    .por_n     (por_n),
    .supply_ok (supply_ok),
    .kick      (kick),
    .sys_rst_n (sys_rst_n),
    .wd_flag_n (wd_flag_n)
  );

  // {req, supply_ok, kick, expected sys_rst_n, expected wd_flag_n}, one per edge
  localparam int NV = 40;
  localparam logic [8:0] VEC [NV] = '{
    {4'd2, 1'b0, F, 1'b0, 1'b1},  // 0  R2 undervoltage
    {4'd3, 1'b1, F, 1'b0, 1'b1},  // 1  R3 reset period starts
    {4'd3, 1'b1, F, 1'b0, 1'b1},
    {4'd3, 1'b1, F, 1'b0, 1'b1},
    {4'd3, 1'b1, F, 1'b0, 1'b1},
    {4'd3, 1'b1, F, 1'b1, 1'b1},  // 5  R3 release
    {4'd9, 1'b1, F, 1'b1, 1'b1},  // 6  R9 float parks watchdog
    {4'd9, 1'b1, F, 1'b1, 1'b1},
    {4'd4, 1'b1, L, 1'b1, 1'b1},  // 8  count 1
    {4'd4, 1'b1, L, 1'b1, 1'b1},
    {4'd5, 1'b1, H, 1'b1, 1'b1},  // 10 R5 kick restarts
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b0, 1'b0},  // 16 R4 timeout
    {4'd6, 1'b1, L, 1'b0, 1'b0},  // 17 R6 kicks ignored in reset
    {4'd6, 1'b1, H, 1'b0, 1'b0},
    {4'd6, 1'b1, L, 1'b0, 1'b0},
    {4'd3, 1'b1, L, 1'b1, 1'b0},  // 20 R3 release, flag latched
    {4'd7, 1'b1, H, 1'b1, 1'b1},  // 21 R7 first kick clears flag
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd4, 1'b1, H, 1'b1, 1'b1},
    {4'd8, 1'b1, H, 1'b0, 1'b0},  // 27 R8 alternation begins
    {4'd8, 1'b1, H, 1'b0, 1'b0},
    {4'd8, 1'b1, H, 1'b0, 1'b0},
    {4'd8, 1'b1, H, 1'b0, 1'b0},
    {4'd8, 1'b1, H, 1'b1, 1'b0},
    {4'd8, 1'b1, H, 1'b1, 1'b0},
    {4'd8, 1'b1, H, 1'b1, 1'b0},
    {4'd8, 1'b1, H, 1'b1, 1'b0},
    {4'd8, 1'b1, H, 1'b1, 1'b0},
    {4'd8, 1'b1, H, 1'b1, 1'b0},
    {4'd8, 1'b1, H, 1'b0, 1'b0},  // 37 R8 reset again
    {4'd10, 1'b0, H, 1'b0, 1'b1}, // 38 R10 undervoltage mid reset
    {4'd2, 1'b1, H, 1'b0, 1'b1}   // 39 R2 full reset period again
  };

  task automatic step(input logic ok, input logic [1:0] k);
    supply_ok = ok;
    kick      = k;
    @(negedge clk);
  endtask

  task automatic chk(input logic er, input logic ef, input string req);
    n_checks++;
    if (sys_rst_n !== er || wd_flag_n !== ef) begin
      n_fail++;
      $display("FAIL %s: sys_rst_n=%b wd_flag_n=%b expected %b %b", req, sys_rst_n, wd_flag_n, er, ef);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, cycles=%0d expected below %0d", cyc, 5000);
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(1'b0, 1'b1, "R1");
    @(negedge clk);
    chk(1'b0, 1'b1, "R1");
    por_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][4], VEC[i][3:2]);
      n_checks++;
      if (sys_rst_n !== VEC[i][1] || wd_flag_n !== VEC[i][0]) begin
        n_fail++;
        $display("FAIL R%0d vec %0d: sys_rst_n=%b wd_flag_n=%b expected %b %b",
                 VEC[i][8:5], i, sys_rst_n, wd_flag_n, VEC[i][1], VEC[i][0]);
      end
    end

    // R3: finish the reset period begun at vector 39
    for (int i = 0; i < 3; i++) step(1'b1, H);
    chk(1'b0, 1'b1, "R3");
    step(1'b1, H);
    chk(1'b1, 1'b1, "R3");

    // R9: floating parks the watchdog with the flag high
    for (int i = 0; i < 20; i++) step(1'b1, F);
    chk(1'b1, 1'b1, "R9");
    for (int i = 0; i < 5; i++) step(1'b1, H);
    chk(1'b1, 1'b1, "R9");
    step(1'b1, H);
    chk(1'b0, 1'b0, "R4");
    for (int i = 0; i < 4; i++) step(1'b1, H);
    chk(1'b1, 1'b0, "R8");

    // R9: floating keeps a latched flag; float to low is no kick
    for (int i = 0; i < 20; i++) step(1'b1, F);
    chk(1'b1, 1'b0, "R9");
    step(1'b1, L);
    chk(1'b1, 1'b0, "R9");
    for (int i = 0; i < 4; i++) step(1'b1, L);
    chk(1'b1, 1'b0, "R9");
    step(1'b1, L);
    chk(1'b0, 1'b0, "R9");
    for (int i = 0; i < 4; i++) step(1'b1, L);
    chk(1'b1, 1'b0, "R6");

    // R5: kick on the expiring edge wins
    for (int i = 0; i < 5; i++) step(1'b1, L);
    chk(1'b1, 1'b0, "R5");
    step(1'b1, H);
    chk(1'b1, 1'b1, "R5");

    // R10: undervoltage on the expiring edge wins, flag high
    for (int i = 0; i < 5; i++) step(1'b1, H);
    chk(1'b1, 1'b1, "R4");
    step(1'b0, H);
    chk(1'b0, 1'b1, "R10");

    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule